// File: doc/BRIEF.md
# Translation Fault Capture and Interrupt Unit

This unit sits beside an address translation engine and keeps a record of the faults it reports. Each fault event arrives with a set of cause bits and the data that goes with it: the virtual address being translated, the physical address involved, and the identifier of the requester. The first fault after an idle period is kept in full. Later faults only add their cause bits to the status until software clears the record. An interrupt line is raised whenever a recorded cause has its enable bit set.

A small register bus lets software set the per-cause enables, read the status and the captured data, and clear the record. The clear is a write-one bit inside the control register. The bus also sets a redirect address, aligned to 128 bytes, that the translation engine uses as a harmless target for faulting accesses. The requester identifier is decoded into a group number and a port number for the outside world. The cause set does not say whether the faulting access was a read or a write.

The capture path is a two-state machine. In `ST_IDLE` nothing is recorded. The transition *capture* (a fault event with a non-zero cause) moves it to `ST_HELD` and loads the data. In `ST_HELD` the transition *accumulate* (a fault without a clear) stays in `ST_HELD` and only ORs in the cause. The transition *release* (a clear with no fault) returns to `ST_IDLE`. The transition *recapture* (a clear and a fault in the same cycle) stays in `ST_HELD` with the new fault loaded as the first one.

Top module: `xlat_fault_unit`

## Requirements
- R1: After reset the status, enables, captured addresses, captured identifier, redirect address and `irq` are all zero, and the decoded group is 6 with port 0.
- R2: The control register at offset 0x220 holds eight enable bits [7:0]: bit 0 translation miss, bit 1 multiple hit, bit 2 invalid physical address, bit 3 entry replacement, bit 4 table walk, bit 5 TLB miss, bit 6 prefetch FIFO overflow, bit 7 miss FIFO overflow. A write takes effect at the next clock edge, and all other bits read as 0.
- R3: `irq` is high exactly when some status bit and its enable bit are both set. It follows a fault or an enable write from the clock edge that records it.
- R4: A fault event with a non-zero cause in `ST_IDLE` loads the cause into the status (0x224, bits [7:0]), the virtual address with bits [11:0] cleared (0x228), the physical address unchanged (0x22C), and the 16-bit requester identifier (0x388, bits [15:0]).
- R5: A fault in `ST_HELD` without a clear ORs its cause into the status and leaves the captured addresses and identifier unchanged.
- R6: Writing the control register with bit 12 set empties the status, drops `irq` and returns the unit to `ST_IDLE`, so the next fault is captured afresh. The same write also loads the enables, and bit 12 always reads as 0.
- R7: A clear and a fault in the same cycle record the fault as a new first fault: the status equals its cause alone, and its data replaces the old data.
- R8: A fault event whose cause bits are all zero changes nothing.
- R9: `req_port` equals captured identifier bits [11:8], and `req_group` equals 6 minus identifier bits [15:13], modulo 8.
- R10: The redirect register at 0x214 stores the written value with bits [6:0] forced to 0, reads back that value and drives `redirect_addr`.
- R11: Writes to the status, captured-data or identifier offsets, or to an unmapped offset, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_valid | input | 1 | Fault event strobe |
| evt_cause | input | 8 | Cause bits of the event, same order as the enables |
| evt_va | input | 32 | Virtual address being translated |
| evt_pa | input | 32 | Physical address involved |
| evt_id | input | 16 | Requester identifier |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |
| redirect_addr | output | 32 | Aligned safe target for faulting accesses |
| req_group | output | 3 | Group decoded from the captured identifier |
| req_port | output | 4 | Port decoded from the captured identifier |

## Verification
The bench targets the boundary between the first fault and later ones. A design that reloads data on every fault would show the second fault's address, and one that overwrites the status instead of ORing it would lose the first cause. A clear that lands in the same cycle as a fault is driven on purpose. A design that gives the clear priority drops that fault, and one that merges them keeps stale cause bits. Zero-cause events, identifier codes 0 and 7 in the group field (which wraps to 7), the read-back of bit 12, and writes to read-only offsets are each checked at the bus or the decode outputs. These show mis-decoding, a sticky clear bit or a writable status.

// File: rtl/xfu_pkg.sv
package xfu_pkg;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 12;
    localparam int N_CAUSE    = 8;
    localparam int ID_W       = 16;
    localparam int PAGE_SHIFT = 12;
    localparam int ALIGN_LOG2 = 7;
    localparam int CLR_BIT    = 12;

    localparam int GRP_LSB    = 13;
    localparam int GRP_W      = 3;
    localparam int PORT_LSB   = 8;
    localparam int PORT_W     = 4;
    localparam int GRP_BASE   = 6;

    localparam logic [ADDR_W-1:0] OFS_PROT = 12'h214;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 12'h220;
    localparam logic [ADDR_W-1:0] OFS_STAT = 12'h224;
    localparam logic [ADDR_W-1:0] OFS_FVA  = 12'h228;
    localparam logic [ADDR_W-1:0] OFS_FPA  = 12'h22C;
    localparam logic [ADDR_W-1:0] OFS_RID  = 12'h388;

    localparam logic [DATA_W-1:0] VA_MASK   = {DATA_W{1'b1}} << PAGE_SHIFT;
    localparam logic [DATA_W-1:0] PROT_MASK = {DATA_W{1'b1}} << ALIGN_LOG2;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HELD = 1'b1
    } cap_state_e;
endpackage

// File: rtl/xfu_capture.sv
module xfu_capture
    import xfu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                evt_valid,
    input  logic [N_CAUSE-1:0]  evt_cause,
    input  logic [DATA_W-1:0]   evt_va,
    input  logic [DATA_W-1:0]   evt_pa,
    input  logic [ID_W-1:0]     evt_id,
    input  logic                clr_pulse,
    output logic [N_CAUSE-1:0]  status_q,
    output logic [DATA_W-1:0]   va_q,
    output logic [DATA_W-1:0]   pa_q,
    output logic [ID_W-1:0]     id_q
);
    cap_state_e state_q, state_d;
    logic       fire;
    logic       take;

    assign fire = evt_valid && (|evt_cause);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and load decision
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (fire) begin
                    state_d = ST_HELD;
                    take    = 1'b1;
                end
            end
            ST_HELD: begin
                if (clr_pulse && fire) begin
                    state_d = ST_HELD;
                    take    = 1'b1;
                end else if (clr_pulse) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // captured data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q <= '0;
            pa_q <= '0;
            id_q <= '0;
        end else if (take) begin
            va_q <= evt_va & VA_MASK;
            pa_q <= evt_pa;
            id_q <= evt_id;
        end
    end

    // cause status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          status_q <= '0;
        else if (take)       status_q <= evt_cause;
        else if (clr_pulse)  status_q <= '0;
        else if (fire)       status_q <= status_q | evt_cause;
    end

    // R5
    accum_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD && !clr_pulse) |=> ($stable(va_q) && $stable(pa_q) && $stable(id_q)));

    // R5
    status_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_pulse |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R6
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse && !fire) |=> (status_q == '0 && state_q == ST_IDLE));

    // R7
    recapture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse && fire) |=> (status_q == $past(evt_cause)));

    // R8
    zero_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_cause == '0 && !clr_pulse) |=> ($stable(status_q) && $stable(va_q)));
endmodule

// File: rtl/xfu_regs.sv
module xfu_regs
    import xfu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic [N_CAUSE-1:0]  status_q,
    input  logic [DATA_W-1:0]   va_q,
    input  logic [DATA_W-1:0]   pa_q,
    input  logic [ID_W-1:0]     id_q,
    output logic [N_CAUSE-1:0]  en_q,
    output logic [DATA_W-1:0]   prot_q,
    output logic                clr_pulse,
    output logic [DATA_W-1:0]   bus_rdata
);
    localparam int STAT_PAD = DATA_W - N_CAUSE;
    localparam int ID_PAD   = DATA_W - ID_W;

    logic wr_ctrl, wr_prot;

    assign wr_ctrl   = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_prot   = bus_wr && (bus_addr == OFS_PROT);
    assign clr_pulse = wr_ctrl && bus_wdata[CLR_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            prot_q <= '0;
        end else begin
            if (wr_ctrl) en_q   <= bus_wdata[N_CAUSE-1:0];
            if (wr_prot) prot_q <= bus_wdata & PROT_MASK;
        end
    end

    always_comb begin
        unique case (bus_addr)
            OFS_PROT: bus_rdata = prot_q;
            OFS_CTRL: bus_rdata = {{STAT_PAD{1'b0}}, en_q};
            OFS_STAT: bus_rdata = {{STAT_PAD{1'b0}}, status_q};
            OFS_FVA:  bus_rdata = va_q;
            OFS_FPA:  bus_rdata = pa_q;
            OFS_RID:  bus_rdata = {{ID_PAD{1'b0}}, id_q};
            default:  bus_rdata = '0;
        endcase
    end

    // R2
    enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (en_q == $past(bus_wdata[N_CAUSE-1:0])));

    // R10
    prot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_prot |=> (prot_q == ($past(bus_wdata) & PROT_MASK)));

    // R11
    prot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_prot |=> $stable(prot_q));
endmodule

// File: rtl/xfu_id_decode.sv
module xfu_id_decode
    import xfu_pkg::*;
(
    input  logic [ID_W-1:0]    id_q,
    output logic [GRP_W-1:0]   req_group,
    output logic [PORT_W-1:0]  req_port
);
    localparam logic [GRP_W-1:0] BASE = GRP_W'(GRP_BASE);

    assign req_port  = id_q[PORT_LSB +: PORT_W];
    assign req_group = BASE - id_q[GRP_LSB +: GRP_W];
endmodule

// File: rtl/xlat_fault_unit.sv
module xlat_fault_unit
    import xfu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                evt_valid,
    input  logic [N_CAUSE-1:0]  evt_cause,
    input  logic [DATA_W-1:0]   evt_va,
    input  logic [DATA_W-1:0]   evt_pa,
    input  logic [ID_W-1:0]     evt_id,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                irq,
    output logic [DATA_W-1:0]   redirect_addr,
    output logic [GRP_W-1:0]    req_group,
    output logic [PORT_W-1:0]   req_port
);
    logic [N_CAUSE-1:0] status_q, en_q, pend;
    logic [DATA_W-1:0]  va_q, pa_q;
    logic [ID_W-1:0]    id_q;
    logic               clr_pulse;

    xfu_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .status_q  (status_q),
        .va_q      (va_q),
        .pa_q      (pa_q),
        .id_q      (id_q),
        .en_q      (en_q),
        .prot_q    (redirect_addr),
        .clr_pulse (clr_pulse),
        .bus_rdata (bus_rdata)
    );

    xfu_capture u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (evt_valid),
        .evt_cause (evt_cause),
        .evt_va    (evt_va),
        .evt_pa    (evt_pa),
        .evt_id    (evt_id),
        .clr_pulse (clr_pulse),
        .status_q  (status_q),
        .va_q      (va_q),
        .pa_q      (pa_q),
        .id_q      (id_q)
    );

    xfu_id_decode u_decode (
        .id_q      (id_q),
        .req_group (req_group),
        .req_port  (req_port)
    );

    for (genvar c = 0; c < N_CAUSE; c++) begin : g_pend
        assign pend[c] = status_q[c] & en_q[c];
    end

    assign irq = |pend;

    // R3
    irq_needs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status_q != '0 && en_q != '0));

    // R6
    irq_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse && !(evt_valid && |evt_cause)) |=> !irq);
endmodule

// File: tb/test_xlat_fault_unit.sv
module test_xlat_fault_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [7:0]  evt_cause = '0;
    logic [31:0] evt_va = '0;
    logic [31:0] evt_pa = '0;
    logic [15:0] evt_id = '0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic [31:0] redirect_addr;
    logic [2:0]  req_group;
    logic [3:0]  req_port;

    int n_checks = 0;
    int n_errors = 0;

    xlat_fault_unit i_xlat_fault_unit (
        .clk(clk), .rst_n(rst_n),
        .evt_valid(evt_valid), .evt_cause(evt_cause), .evt_va(evt_va),
        .evt_pa(evt_pa), .evt_id(evt_id),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .redirect_addr(redirect_addr),
        .req_group(req_group), .req_port(req_port)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic fault(input logic [7:0] c, input logic [31:0] va,
                         input logic [31:0] pa, input logic [15:0] id);
        @(negedge clk);
        evt_valid = 1'b1; evt_cause = c; evt_va = va; evt_pa = pa; evt_id = id;
        @(negedge clk);
        evt_valid = 1'b0; evt_cause = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(12'h220, d); check("R1 ctrl", d, 0);
        rd(12'h224, d); check("R1 status", d, 0);
        rd(12'h228, d); check("R1 va", d, 0);
        rd(12'h22C, d); check("R1 pa", d, 0);
        rd(12'h388, d); check("R1 id", d, 0);
        rd(12'h214, d); check("R1 prot", d, 0);
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 group", {29'b0, req_group}, 6);
        check("R1 port", {28'b0, req_port}, 0);
    endtask

    task automatic t_enables();
        logic [31:0] d;
        wr(12'h220, 32'hFFFF_E0A5);
        rd(12'h220, d); check("R2 enable readback", d, 32'h0000_00A5);
        fault(8'h02, 32'h0000_3000, 32'h1, 16'h0);
        check("R3 irq masked cause", {31'b0, irq}, 0);
        wr(12'h220, 32'h0000_0002);
        check("R3 irq after enable", {31'b0, irq}, 1);
        wr(12'h220, 32'h0000_1000);
        check("R6 irq after clear", {31'b0, irq}, 0);
        rd(12'h224, d); check("R6 status after clear", d, 0);
    endtask

    task automatic t_capture();
        logic [31:0] d;
        wr(12'h220, 32'h0000_10FF);
        fault(8'h01, 32'h1234_5ABC, 32'hCAFE_0123, 16'hA5C3);
        rd(12'h224, d); check("R4 status", d, 32'h01);
        rd(12'h228, d); check("R4 va", d, 32'h1234_5000);
        rd(12'h22C, d); check("R4 pa", d, 32'hCAFE_0123);
        rd(12'h388, d); check("R4 id", d, 32'h0000_A5C3);
        check("R3 irq", {31'b0, irq}, 1);
        check("R9 group", {29'b0, req_group}, 1);
        check("R9 port", {28'b0, req_port}, 5);
    endtask

    task automatic t_accumulate();
        logic [31:0] d;
        fault(8'h10, 32'h7777_7777, 32'h8888_8888, 16'h1234);
        rd(12'h224, d); check("R5 status or", d, 32'h11);
        rd(12'h228, d); check("R5 va held", d, 32'h1234_5000);
        rd(12'h22C, d); check("R5 pa held", d, 32'hCAFE_0123);
        rd(12'h388, d); check("R5 id held", d, 32'h0000_A5C3);
    endtask

    task automatic t_clear_recapture();
        logic [31:0] d;
        wr(12'h220, 32'h0000_10FF);
        rd(12'h224, d); check("R6 status cleared", d, 0);
        rd(12'h220, d); check("R6 clear bit reads 0", d, 32'hFF);
        check("R6 irq low", {31'b0, irq}, 0);
        fault(8'h80, 32'hFFFF_FFFF, 32'h0BAD_F00D, 16'hE000);
        rd(12'h224, d); check("R6 fresh status", d, 32'h80);
        rd(12'h228, d); check("R6 fresh va", d, 32'hFFFF_F000);
        check("R9 group wrap", {29'b0, req_group}, 7);
        check("R9 port zero", {28'b0, req_port}, 0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] d;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h220; bus_wdata = 32'h0000_10FF;
        evt_valid = 1'b1; evt_cause = 8'h04; evt_va = 32'h0000_1FFF;
        evt_pa = 32'h5555_AAAA; evt_id = 16'h0F00;
        @(negedge clk);
        bus_wr = 1'b0; evt_valid = 1'b0; evt_cause = '0;
        rd(12'h224, d); check("R7 status new only", d, 32'h04);
        rd(12'h228, d); check("R7 va new", d, 32'h0000_1000);
        rd(12'h22C, d); check("R7 pa new", d, 32'h5555_AAAA);
        check("R7 irq", {31'b0, irq}, 1);
        check("R9 group id0", {29'b0, req_group}, 6);
        check("R9 port 15", {28'b0, req_port}, 15);
    endtask

    task automatic t_zero_cause();
        logic [31:0] d;
        fault(8'h00, 32'h9999_9000, 32'h9, 16'h9999);
        rd(12'h224, d); check("R8 status held", d, 32'h04);
        rd(12'h228, d); check("R8 va held", d, 32'h0000_1000);
        wr(12'h220, 32'h0000_10FF);
        fault(8'h00, 32'h9999_9000, 32'h9, 16'h9999);
        rd(12'h224, d); check("R8 idle status", d, 0);
        rd(12'h388, d); check("R8 idle id", d, 32'h0F00);
        check("R8 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_protect();
        logic [31:0] d;
        wr(12'h214, 32'h8765_43FF);
        rd(12'h214, d); check("R10 readback", d, 32'h8765_4380);
        check("R10 output", redirect_addr, 32'h8765_4380);
    endtask

    task automatic t_readonly();
        logic [31:0] d;
        fault(8'h20, 32'h4444_4444, 32'h3333_3333, 16'h2222);
        wr(12'h224, 32'hFFFF_FFFF);
        wr(12'h228, 32'h0);
        wr(12'h22C, 32'h0);
        wr(12'h388, 32'hFFFF);
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h224, d); check("R11 status", d, 32'h20);
        rd(12'h228, d); check("R11 va", d, 32'h4444_4000);
        rd(12'h22C, d); check("R11 pa", d, 32'h3333_3333);
        rd(12'h388, d); check("R11 id", d, 32'h2222);
        rd(12'h220, d); check("R11 ctrl", d, 32'hFF);
        rd(12'h214, d); check("R11 prot", d, 32'h8765_4380);
        rd(12'h000, d); check("R11 unmapped", d, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enables();
        t_capture();
        t_accumulate();
        t_clear_recapture();
        t_same_cycle();
        t_zero_cause();
        t_protect();
        t_readonly();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule